// File: doc/BRIEF.md
# Status Condition-Code Unit

This block holds a processor's 16-bit status word and keeps its 2-bit condition code up to date. Three kinds of operation produce a code: a sign/zero test of an operand one to four 16-bit words wide, a character-class test of a byte, and a magnitude comparison of two 32-bit operands. Each of them can run in signed or unsigned mode. Separate strobes write the carry and overflow bits. A load operation replaces the whole word.

The stored code does not suit a direct mask test, because "greater" is encoded as 00. The block therefore turns the code into a 3-bit one-hot flag and ANDs it with a condition mask from the instruction. The result is a branch-taken signal. Setting overflow while traps are enabled raises a one-cycle integer-overflow trap request.

The status word is laid out as follows, counting from bit 15 down:
- bit 15: mode
- bit 14: interrupt enable
- bit 13: trap enable
- bit 12: right-hand stack operation
- bit 11: overflow
- bit 10: carry
- bits 9:8: condition code
- bits 7:0: current code segment number

Condition codes are 00 greater, 01 less, 10 equal and 11 invalid.

Top module: `status_cc_unit`

## Requirements
- R1: While `rst_n` is low and until the first operation, `status` reads 0 and `ovf_trap` reads 0.
- R2: Arithmetic operation (`op_sel`=1), signed mode: the operand is `opnd_a` limited to its low `arith_len`+1 words, and bits above them are ignored. An all-zero operand gives 10. Otherwise, bit 16*(`arith_len`+1)-1 set gives 01, and clear gives 00.
- R3: Arithmetic operation, unsigned mode (`signed_mode`=0): zero gives 10, and any nonzero operand gives 00.
- R4: Byte operation (`op_sel`=2) on `opnd_a[7:0]`:
  - 8'h30 to 8'h39 give 00.
  - 8'h41 to 8'h5A and 8'h61 to 8'h7A give 10.
  - Every other byte gives 01.
  - `opnd_a[63:8]` is ignored.
- R5: Compare operation (`op_sel`=3), signed mode: `opnd_a[31:0]` and `opnd_b[31:0]` are compared as two's-complement values. The result is 00 if a>b, 01 if a<b and 10 if they are equal.
- R6: Compare operation, unsigned mode: the same encoding, with both operands taken as unsigned values.
- R7: Operations 1 to 3 write only bits 9:8. Bits 15:10 and 7:0 keep their values unless a carry or overflow strobe is active in the same cycle.
- R8: Load operation (`op_sel`=4) writes `opnd_a[15:0]` to all 16 status bits. Codes 0 and 5 to 7 leave the status unchanged.
- R9: `carry_we` writes `carry_in` to bit 10, and `ovf_we` writes `ovf_in` to bit 11. A strobe overrides the same bit of a load in the same cycle.
- R10: `ovf_trap` is 1 in the cycle after an edge at which `ovf_we`=1, `ovf_in`=1 and bit 13 was 1. It is 0 after every other edge, including edges where overflow is cleared.
- R11: The flag is 3'b100 for code 00, 3'b001 for 01 and 3'b010 for 10. `branch_taken` = |(`cond_mask` & flag), combinationally from the current status, so a mask of 3'b110 matches either greater or equal.
- R12: The invalid code 11 gives flag 3'b011, which matches masks holding the less or the equal bit and never the greater bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_sel | input | 3 | 0 none, 1 arithmetic, 2 byte, 3 compare, 4 load |
| arith_len | input | 2 | Arithmetic operand width in words minus one |
| signed_mode | input | 1 | 1 signed, 0 unsigned |
| opnd_a | input | 64 | First operand / load value |
| opnd_b | input | 32 | Second compare operand |
| carry_we | input | 1 | Carry write strobe |
| carry_in | input | 1 | Carry value |
| ovf_we | input | 1 | Overflow write strobe |
| ovf_in | input | 1 | Overflow value |
| cond_mask | input | 3 | Branch condition mask: bit2 greater, bit1 equal, bit0 less |
| status | output | 16 | Status register |
| branch_taken | output | 1 | Mask matched current condition flag |
| ovf_trap | output | 1 | Integer-overflow trap request pulse |

## Verification
Status and trap results are registered, so each is due at the first rising edge after the stimulus. The bench drives inputs on a falling edge and reads `status` and `ovf_trap` at the next falling edge, then checks that the trap has dropped one cycle later. `branch_taken` depends only on the current status and the mask. It is read a short delay after the mask changes, with no clock edge in between. After reset the bench waits out the reset synchronizer before making its first operation check.

// File: rtl/sccu_pkg.sv
package sccu_pkg;
  localparam int STAT_W   = 16;
  localparam int BIT_MODE = 15;
  localparam int BIT_IEN  = 14;
  localparam int BIT_TEN  = 13;
  localparam int BIT_RSTK = 12;
  localparam int BIT_OVF  = 11;
  localparam int BIT_CRY  = 10;
  localparam int CC_HI    = 9;
  localparam int CC_LO    = 8;

  localparam logic [1:0] CC_GT  = 2'b00;
  localparam logic [1:0] CC_LT  = 2'b01;
  localparam logic [1:0] CC_EQ  = 2'b10;
  localparam logic [1:0] CC_INV = 2'b11;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ARITH = 3'd1,
    OP_BYTE  = 3'd2,
    OP_CMP   = 3'd3,
    OP_LOAD  = 3'd4
  } op_e;
endpackage

// File: rtl/cc_arith.sv
module cc_arith
  import sccu_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 4,
  localparam int OPA_W    = WORD_W * MAX_WORDS,
  localparam int LEN_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic [OPA_W-1:0] opnd,
  input  logic [LEN_W-1:0] len,
  input  logic             signed_mode,
  output logic [1:0]       cc
);
  logic [MAX_WORDS-1:0] word_nz;
  logic [MAX_WORDS-1:0] in_range;
  logic [MAX_WORDS-1:0] word_sign;

  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word
    assign word_nz[i]   = |opnd[i*WORD_W +: WORD_W];
    assign word_sign[i] = opnd[i*WORD_W + WORD_W - 1];
    assign in_range[i]  = (LEN_W'(i) <= len);
  end

  logic any_nz;
  logic top_sign;

  always_comb begin
    any_nz   = |(word_nz & in_range);
    top_sign = word_sign[len];
    if (!any_nz)                    cc = CC_EQ;
    else if (signed_mode && top_sign) cc = CC_LT;
    else                            cc = CC_GT;
  end

  // R2
  always_comb begin
    if (opnd == '0) begin
      zero_is_equal_chk: assert (cc == CC_EQ);
    end
  end
endmodule

// File: rtl/cc_byte.sv
module cc_byte
  import sccu_pkg::*;
(
  input  logic [7:0] ch,
  output logic [1:0] cc
);
  logic is_digit;
  logic is_upper;
  logic is_lower;

  always_comb begin
    is_digit = (ch >= 8'h30) && (ch <= 8'h39);
    is_upper = (ch >= 8'h41) && (ch <= 8'h5A);
    is_lower = (ch >= 8'h61) && (ch <= 8'h7A);
    if (is_digit)                cc = CC_GT;
    else if (is_upper || is_lower) cc = CC_EQ;
    else                         cc = CC_LT;
  end

  // R4
  always_comb begin
    byte_never_invalid_chk: assert (cc != CC_INV);
  end
endmodule

// File: rtl/cc_compare.sv
module cc_compare
  import sccu_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CMP_W = 2 * WORD_W
) (
  input  logic [CMP_W-1:0] a,
  input  logic [CMP_W-1:0] b,
  input  logic             signed_mode,
  output logic [1:0]       cc
);
  logic [WORD_W-1:0] flip;
  logic [WORD_W-1:0] hi_a;
  logic [WORD_W-1:0] hi_b;
  logic [WORD_W-1:0] lo_a;
  logic [WORD_W-1:0] lo_b;

  always_comb begin
    flip = {signed_mode, {(WORD_W-1){1'b0}}};
    hi_a = a[CMP_W-1:WORD_W] ^ flip;
    hi_b = b[CMP_W-1:WORD_W] ^ flip;
    lo_a = a[WORD_W-1:0];
    lo_b = b[WORD_W-1:0];
    if (hi_a == hi_b) begin
      if (lo_a == lo_b)     cc = CC_EQ;
      else if (lo_a < lo_b) cc = CC_LT;
      else                  cc = CC_GT;
    end else if (hi_a < hi_b) begin
      cc = CC_LT;
    end else begin
      cc = CC_GT;
    end
  end

  // R5
  always_comb begin
    cmp_equal_chk: assert ((a == b) == (cc == CC_EQ));
  end
endmodule

// File: rtl/cc_branch.sv
module cc_branch
  import sccu_pkg::*;
(
  input  logic [1:0] cc,
  input  logic [2:0] mask,
  output logic [2:0] flag,
  output logic       taken
);
  always_comb begin
    flag  = (cc == CC_GT) ? 3'b100 : {1'b0, cc};
    taken = |(mask & flag);
  end

  // R11
  always_comb begin
    if (cc != CC_INV) begin
      flag_onehot_chk: assert ($onehot(flag));
    end
    if (mask == 3'b000) begin
      empty_mask_chk: assert (!taken);
    end
  end
endmodule

// File: rtl/status_cc_unit.sv
module status_cc_unit
  import sccu_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 4,
  localparam int OPA_W    = WORD_W * MAX_WORDS,
  localparam int CMP_W    = 2 * WORD_W,
  localparam int LEN_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_sel,
  input  logic [LEN_W-1:0]  arith_len,
  input  logic              signed_mode,
  input  logic [OPA_W-1:0]  opnd_a,
  input  logic [CMP_W-1:0]  opnd_b,
  input  logic              carry_we,
  input  logic              carry_in,
  input  logic              ovf_we,
  input  logic              ovf_in,
  input  logic [2:0]        cond_mask,
  output logic [STAT_W-1:0] status,
  output logic              branch_taken,
  output logic              ovf_trap
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // condition-code sources
  logic [1:0] arith_cc;
  logic [1:0] byte_cc;
  logic [1:0] cmp_cc;
  logic [2:0] cc_flag;

  cc_arith #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_arith (
    .opnd        (opnd_a),
    .len         (arith_len),
    .signed_mode (signed_mode),
    .cc          (arith_cc)
  );

  cc_byte u_byte (
    .ch (opnd_a[7:0]),
    .cc (byte_cc)
  );

  cc_compare #(.WORD_W(WORD_W)) u_cmp (
    .a           (opnd_a[CMP_W-1:0]),
    .b           (opnd_b),
    .signed_mode (signed_mode),
    .cc          (cmp_cc)
  );

  // next state
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              trap_q, trap_d;
  logic              stat_en;
  logic              cc_op;

  always_comb begin
    stat_d = stat_q;
    trap_d = 1'b0;
    cc_op  = 1'b0;
    case (op_sel)
      OP_ARITH: begin stat_d[CC_HI:CC_LO] = arith_cc; cc_op = 1'b1; end
      OP_BYTE:  begin stat_d[CC_HI:CC_LO] = byte_cc;  cc_op = 1'b1; end
      OP_CMP:   begin stat_d[CC_HI:CC_LO] = cmp_cc;   cc_op = 1'b1; end
      OP_LOAD:  stat_d = opnd_a[STAT_W-1:0];
      default:  ;
    endcase
    if (carry_we) stat_d[BIT_CRY] = carry_in;
    if (ovf_we) begin
      stat_d[BIT_OVF] = ovf_in;
      trap_d          = ovf_in & stat_q[BIT_TEN];
    end
    stat_en = cc_op || (op_sel == OP_LOAD) || carry_we || ovf_we;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stat_q <= '0;
      trap_q <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      trap_q <= trap_d;
    end
  end

  cc_branch u_branch (
    .cc    (stat_q[CC_HI:CC_LO]),
    .mask  (cond_mask),
    .flag  (cc_flag),
    .taken (branch_taken)
  );

  assign status   = stat_q;
  assign ovf_trap = trap_q;

  // R7
  cc_field_only_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((op_sel inside {OP_ARITH, OP_BYTE, OP_CMP}) && !carry_we && !ovf_we) |=>
      (status[STAT_W-1:CC_HI+1] == $past(status[STAT_W-1:CC_HI+1])) &&
      (status[CC_LO-1:0] == $past(status[CC_LO-1:0])));

  // R8
  load_word_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((op_sel == OP_LOAD) && !carry_we && !ovf_we) |=>
      (status == $past(opnd_a[STAT_W-1:0])));

  // R9
  carry_strobe_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    carry_we |=> (status[BIT_CRY] == $past(carry_in)));

  // R10
  ovf_trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ovf_we && ovf_in && status[BIT_TEN]) |=> ovf_trap);

  // R10
  no_trap_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(ovf_we && ovf_in) |=> !ovf_trap);
endmodule

// File: tb/tb_status_cc_unit.sv
module tb_status_cc_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  len;
    logic        sgn;
    logic [63:0] a;
    logic [31:0] b;
    logic [1:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    // R2 signed arithmetic
    '{3'd1, 2'd0, 1'b1, 64'h0,                     32'h0, 2'b10, 4'd2},
    '{3'd1, 2'd0, 1'b1, 64'h8000,                  32'h0, 2'b01, 4'd2},
    '{3'd1, 2'd0, 1'b1, 64'h0001,                  32'h0, 2'b00, 4'd2},
    '{3'd1, 2'd0, 1'b1, 64'hFFFF_0000,             32'h0, 2'b10, 4'd2},
    '{3'd1, 2'd1, 1'b1, 64'h8000_0000,             32'h0, 2'b01, 4'd2},
    '{3'd1, 2'd1, 1'b1, 64'h0000_8000,             32'h0, 2'b00, 4'd2},
    '{3'd1, 2'd3, 1'b1, 64'h1,                     32'h0, 2'b00, 4'd2},
    '{3'd1, 2'd3, 1'b1, 64'h8000_0000_0000_0000,   32'h0, 2'b01, 4'd2},
    '{3'd1, 2'd2, 1'b1, 64'h0000_8000_0000_0000,   32'h0, 2'b01, 4'd2},
    // R3 unsigned arithmetic
    '{3'd1, 2'd0, 1'b0, 64'h8000,                  32'h0, 2'b00, 4'd3},
    '{3'd1, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF,   32'h0, 2'b00, 4'd3},
    '{3'd1, 2'd3, 1'b0, 64'h0,                     32'h0, 2'b10, 4'd3},
    // R4 byte class
    '{3'd2, 2'd0, 1'b0, 64'h30,   32'h0, 2'b00, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'h39,   32'h0, 2'b00, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'h2F,   32'h0, 2'b01, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'h3A,   32'h0, 2'b01, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'h41,   32'h0, 2'b10, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'h5A,   32'h0, 2'b10, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'h40,   32'h0, 2'b01, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'h5B,   32'h0, 2'b01, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'h61,   32'h0, 2'b10, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'h7A,   32'h0, 2'b10, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'h60,   32'h0, 2'b01, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'h7B,   32'h0, 2'b01, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'hFF41, 32'h0, 2'b10, 4'd4},
    '{3'd2, 2'd0, 1'b0, 64'hC1,   32'h0, 2'b01, 4'd4},
    // R5 signed compare
    '{3'd3, 2'd0, 1'b1, 64'hFFFF_FFFF, 32'h0000_0001, 2'b01, 4'd5},
    '{3'd3, 2'd0, 1'b1, 64'h0000_0001, 32'hFFFF_FFFF, 2'b00, 4'd5},
    '{3'd3, 2'd0, 1'b1, 64'h1234_5678, 32'h1234_5678, 2'b10, 4'd5},
    '{3'd3, 2'd0, 1'b1, 64'h0001_0002, 32'h0001_0003, 2'b01, 4'd5},
    '{3'd3, 2'd0, 1'b1, 64'h8000_0000, 32'h7FFF_FFFF, 2'b01, 4'd5},
    // R6 unsigned compare
    '{3'd3, 2'd0, 1'b0, 64'hFFFF_FFFF, 32'h0000_0001, 2'b00, 4'd6},
    '{3'd3, 2'd0, 1'b0, 64'h8000_0000, 32'h7FFF_FFFF, 2'b00, 4'd6},
    '{3'd3, 2'd0, 1'b0, 64'h0001_0003, 32'h0001_0002, 2'b00, 4'd6},
    '{3'd3, 2'd0, 1'b0, 64'h0,         32'h0,         2'b10, 4'd6},
    '{3'd3, 2'd0, 1'b0, 64'h1,         32'h2,         2'b01, 4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [1:0]  arith_len = 2'd0;
  logic        signed_mode = 1'b0;
  logic [63:0] opnd_a = 64'h0;
  logic [31:0] opnd_b = 32'h0;
  logic        carry_we = 1'b0;
  logic        carry_in = 1'b0;
  logic        ovf_we = 1'b0;
  logic        ovf_in = 1'b0;
  logic [2:0]  cond_mask = 3'b000;
  logic [15:0] status;
  logic        branch_taken;
  logic        ovf_trap;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_cc_unit dut (
    .clk, .rst_n, .op_sel, .arith_len, .signed_mode, .opnd_a, .opnd_b,
    .carry_we, .carry_in, .ovf_we, .ovf_in, .cond_mask,
    .status, .branch_taken, .ovf_trap
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] flag_of(input logic [1:0] cc);
    return (cc == 2'b00) ? 3'b100 : {1'b0, cc};
  endfunction

  task automatic apply(input logic [2:0] op, input logic [63:0] a);
    @(negedge clk);
    op_sel = op;
    opnd_a = a;
    @(negedge clk);
    op_sel = 3'd0;
    carry_we = 1'b0;
    ovf_we = 1'b0;
  endtask

  task automatic mask_chk(input string req, input logic [2:0] m, input logic exp);
    cond_mask = m;
    #1;
    chk(req, {31'h0, branch_taken}, {31'h0, exp});
  endtask

  localparam logic [15:0] PRELOAD = 16'hFC5A;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", {16'h0, status}, 32'h0);
    chk("R1 trap", {31'h0, ovf_trap}, 32'h0);
    mask_chk("R1 R11 greater after reset", 3'b100, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 status after release", {16'h0, status}, 32'h0);

    // R8 load preset
    apply(3'd4, {48'h0, PRELOAD});
    chk("R8 load", {16'h0, status}, {16'h0, PRELOAD});

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_sel      = VECS[i].op;
      arith_len   = VECS[i].len;
      signed_mode = VECS[i].sgn;
      opnd_a      = VECS[i].a;
      opnd_b      = VECS[i].b;
      @(negedge clk);
      op_sel = 3'd0;
      chk($sformatf("R%0d vec %0d cc", VECS[i].req, i), {30'h0, status[9:8]}, {30'h0, VECS[i].exp});
      // R7 other bits preserved
      chk($sformatf("R7 vec %0d other bits", i), {16'h0, status & 16'hFCFF}, {16'h0, PRELOAD & 16'hFCFF});
      // R11 branch match on own flag and on its complement
      mask_chk($sformatf("R11 vec %0d match", i), flag_of(VECS[i].exp), 1'b1);
      mask_chk($sformatf("R11 vec %0d miss", i), ~flag_of(VECS[i].exp), 1'b0);
    end

    // R8 only trap enable set; R9 R10 overflow with traps enabled
    apply(3'd4, 64'h2000);
    chk("R8 load te", {16'h0, status}, 32'h2000);
    @(negedge clk); ovf_we = 1'b1; ovf_in = 1'b1;
    @(negedge clk); ovf_we = 1'b0;
    chk("R9 ovf set", {16'h0, status}, 32'h2800);
    chk("R10 trap raised", {31'h0, ovf_trap}, 32'h1);
    @(negedge clk);
    chk("R10 trap one cycle", {31'h0, ovf_trap}, 32'h0);
    @(negedge clk); ovf_we = 1'b1; ovf_in = 1'b0;
    @(negedge clk); ovf_we = 1'b0;
    chk("R9 ovf clear", {16'h0, status}, 32'h2000);
    chk("R10 clear no trap", {31'h0, ovf_trap}, 32'h0);
    @(negedge clk); carry_we = 1'b1; carry_in = 1'b1;
    @(negedge clk); carry_we = 1'b0;
    chk("R9 carry set", {16'h0, status}, 32'h2400);
    @(negedge clk); carry_we = 1'b1; carry_in = 1'b0;
    @(negedge clk); carry_we = 1'b0;
    chk("R9 carry clear", {16'h0, status}, 32'h2000);

    // R10 traps disabled
    apply(3'd4, 64'h0);
    @(negedge clk); ovf_we = 1'b1; ovf_in = 1'b1;
    @(negedge clk); ovf_we = 1'b0;
    chk("R10 te=0 status", {16'h0, status}, 32'h0800);
    chk("R10 te=0 no trap", {31'h0, ovf_trap}, 32'h0);

    // R9 strobe overrides load; strobe alongside cc op
    @(negedge clk); carry_we = 1'b1; carry_in = 1'b1;
    apply(3'd4, 64'h1234);
    chk("R9 carry over load", {16'h0, status}, 32'h1634);
    @(negedge clk); carry_we = 1'b1; carry_in = 1'b0;
    arith_len = 2'd0; signed_mode = 1'b1;
    apply(3'd1, 64'h0);
    chk("R9 R2 carry with arith", {16'h0, status}, 32'h1234);

    // R8 unused op codes do nothing
    apply(3'd6, 64'hFFFF);
    chk("R8 unused op", {16'h0, status}, 32'h1234);

    // R12 invalid code
    apply(3'd4, 64'h0300);
    mask_chk("R12 less", 3'b001, 1'b1);
    mask_chk("R12 equal", 3'b010, 1'b1);
    mask_chk("R12 greater", 3'b100, 1'b0);

    // R11 combined masks
    apply(3'd4, 64'h0200);
    mask_chk("R11 ge on equal", 3'b110, 1'b1);
    mask_chk("R11 ne on equal", 3'b101, 1'b0);
    mask_chk("R11 empty", 3'b000, 1'b0);
    apply(3'd4, 64'h0000);
    mask_chk("R11 ge on greater", 3'b110, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule